// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one unsigned integer by another over many clock cycles using the restoring method. A single pulse on `start` captures the dividend and divisor while the unit is idle. The dividend is placed in the low half of a double-width working register whose upper half begins at zero. Each step shifts the whole register left by one bit and tries to subtract the divisor from the upper half. If the divisor fits, the difference is kept and a 1 enters the vacated least significant bit. If it does not fit, a 0 enters that bit and the upper half gets back its value from before the subtraction. After one step per dividend bit, the low half holds the quotient and the upper half holds the remainder.

A single adder/subtractor serves every step, and no separate quotient register exists. The parameter `RESTORE_EXPLICIT` selects how a failed trial is undone. With 1 (the default), an extra cycle adds the divisor back through the same adder, so latency depends on the data. With 0, a multiplexer keeps the shifted value, and every bit takes exactly one cycle. While `busy` is high the unit ignores new requests. `done` pulses for one cycle when results are ready. The results then stay on `hi` (remainder) and `lo` (quotient) until the next request is accepted. A zero divisor needs no special handling: it completes normally.

Top module: `rdiv_core`

## Requirements
- R1: After reset, `busy`, `done`, `hi` and `lo` are all zero.
- R2: A `start` high at a rising edge while neither `busy` nor `done` is high is accepted. After that edge, `busy` is 1, `hi` is 0 and `lo` equals the captured dividend.
- R3: On the cycle `done` is high, `lo` equals the unsigned quotient and `hi` equals the remainder. For example, 7 divided by 2 gives `lo`=3 and `hi`=1. For a non-zero divisor, `hi` is below the divisor.
- R4: `done` is high for exactly one cycle, and `busy` is low in that cycle. `hi` and `lo` then hold their values until the next accepted `start`.
- R5: `start` is ignored while `busy` is high. Operands presented with it do not change the result of the division in progress.
- R6: A divisor of zero completes normally, with `lo` all ones and `hi` equal to the dividend.
- R7: With `RESTORE_EXPLICIT`=1, `done` rises after rising edge number WIDTH+Z counted from the accepting edge, where Z is the number of zero bits in the quotient.
- R8: With `RESTORE_EXPLICIT`=0, `done` rises after rising edge number WIDTH counted from the accepting edge, for every operand pair.
- R9: Results stay exact when the shifted partial remainder overflows WIDTH bits, i.e. when the divisor has its top bit set (for WIDTH=32, 0xFFFFFFFF divided by 0x80000001 gives quotient 1 and remainder 0x7FFFFFFE).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| dividend | input | WIDTH | Unsigned dividend, captured on the accepting edge |
| divisor | input | WIDTH | Unsigned divisor, captured on the accepting edge |
| busy | output | 1 | High while division steps are running |
| done | output | 1 | One-cycle pulse when results are valid |
| hi | output | WIDTH | Remainder |
| lo | output | WIDTH | Quotient |

## Verification
The bench builds two instances. The first uses WIDTH=32 with the explicit restore cycle. It covers the full-width corners: an overflowing shifted remainder with a top-bit divisor, an all-ones dividend, and latency that varies with the count of zero quotient bits. The second uses WIDTH=8 with the multiplexer restore. Its small operand space allows a broad grid of dividend and divisor pairs, including zero divisors, in little time. The grid checks both exact results and the fixed one-cycle-per-bit latency.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

   typedef enum logic [1:0] {
      RD_IDLE = 2'd0,
      RD_STEP = 2'd1,
      RD_FIX  = 2'd2,
      RD_END  = 2'd3
   } rdiv_state_e;

endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
   import rdiv_pkg::*;
#(
   parameter int WIDTH            = 32,
   parameter int RESTORE_EXPLICIT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic trial_neg,
   output logic load,
   output logic step_en,
   output logic fix_en,
   output logic busy,
   output logic done
);

   localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

   rdiv_state_e      state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             go_fix;
   logic             bit_done;

   generate
      if (RESTORE_EXPLICIT != 0) begin : g_fix_cycle
         assign go_fix = trial_neg;
      end else begin : g_mux_restore
         assign go_fix = 1'b0;
      end
   endgenerate

   assign load     = (state_q == RD_IDLE) && start;
   assign step_en  = (state_q == RD_STEP);
   assign fix_en   = (state_q == RD_FIX);
   assign bit_done = ((state_q == RD_STEP) && !go_fix) || (state_q == RD_FIX);
   assign busy     = (state_q == RD_STEP) || (state_q == RD_FIX);
   assign done     = (state_q == RD_END);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      case (state_q)
         RD_IDLE: begin
            if (start) begin
               state_d = RD_STEP;
               cnt_d   = '0;
            end
         end
         RD_STEP: begin
            if (go_fix) begin
               state_d = RD_FIX;
            end
         end
         RD_FIX:  state_d = RD_STEP;
         RD_END:  state_d = RD_IDLE;
         default: state_d = RD_IDLE;
      endcase
      if (bit_done) begin
         if (cnt_q == LAST) begin
            state_d = RD_END;
         end else begin
            state_d = RD_STEP;
            cnt_d   = cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RD_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

endmodule

// File: rtl/rdiv_addsub.sv
module rdiv_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH:0]   op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             sub,
   output logic [WIDTH:0]   sum
);

   logic [WIDTH:0] b_ext;

   // one adder: subtraction adds the inverted operand with a carry-in of one
   assign b_ext = {1'b0, op_b} ^ {(WIDTH + 1){sub}};
   assign sum   = op_a + b_ext + {{WIDTH{1'b0}}, sub};

endmodule

// File: rtl/rdiv_remreg.sv
module rdiv_remreg #(
   parameter int WIDTH            = 32,
   parameter int RESTORE_EXPLICIT = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [WIDTH-1:0]   dividend,
   input  logic               step_en,
   input  logic               fix_en,
   input  logic               trial_neg,
   input  logic [WIDTH:0]     alu_sum,
   output logic [2*WIDTH-1:0] rem_q
);

   localparam int RW = 2 * WIDTH;

   logic [WIDTH-1:0] neg_hi;
   logic [WIDTH-1:0] step_hi;

   generate
      if (RESTORE_EXPLICIT != 0) begin : g_keep_diff
         // difference is kept now and undone by the following add cycle
         assign neg_hi = alu_sum[WIDTH-1:0];
      end else begin : g_keep_shift
         assign neg_hi = rem_q[RW-2:WIDTH-1];
      end
   endgenerate

   assign step_hi = trial_neg ? neg_hi : alu_sum[WIDTH-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (load) begin
         rem_q <= {{WIDTH{1'b0}}, dividend};
      end else if (step_en) begin
         rem_q <= {step_hi, rem_q[WIDTH-2:0], ~trial_neg};
      end else if (fix_en) begin
         rem_q[RW-1:WIDTH] <= alu_sum[WIDTH-1:0];
      end
   end

endmodule

// File: rtl/rdiv_core.sv
module rdiv_core #(
   parameter int WIDTH            = 32,
   parameter int RESTORE_EXPLICIT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] hi,
   output logic [WIDTH-1:0] lo
);

   localparam int RW = 2 * WIDTH;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("rdiv_core: WIDTH must be at least 2");
      end
      if (RESTORE_EXPLICIT != 0 && RESTORE_EXPLICIT != 1) begin : g_bad_mode
         $error("rdiv_core: RESTORE_EXPLICIT must be 0 or 1");
      end
   endgenerate

   logic [WIDTH-1:0] dvs_q;
   logic [RW-1:0]    rem_q;
   logic [WIDTH:0]   op_a;
   logic [WIDTH:0]   alu_sum;
   logic             alu_sub;
   logic             trial_neg;
   logic             load, step_en, fix_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dvs_q <= '0;
      end else if (load) begin
         dvs_q <= divisor;
      end
   end

   generate
      if (RESTORE_EXPLICIT != 0) begin : g_op_fix
         assign alu_sub = !fix_en;
         assign op_a    = fix_en ? {1'b0, rem_q[RW-1:WIDTH]}
                                 : {rem_q[RW-1], rem_q[RW-2:WIDTH-1]};
      end else begin : g_op_step
         assign alu_sub = 1'b1;
         assign op_a    = {rem_q[RW-1], rem_q[RW-2:WIDTH-1]};
      end
   endgenerate

   // a carried-out top bit means the shifted remainder already exceeds any divisor
   assign trial_neg = !rem_q[RW-1] && alu_sum[WIDTH];

   rdiv_addsub #(.WIDTH(WIDTH)) u_alu (
      .op_a (op_a),
      .op_b (dvs_q),
      .sub  (alu_sub),
      .sum  (alu_sum)
   );

   rdiv_ctrl #(.WIDTH(WIDTH), .RESTORE_EXPLICIT(RESTORE_EXPLICIT)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .trial_neg (trial_neg),
      .load      (load),
      .step_en   (step_en),
      .fix_en    (fix_en),
      .busy      (busy),
      .done      (done)
   );

   rdiv_remreg #(.WIDTH(WIDTH), .RESTORE_EXPLICIT(RESTORE_EXPLICIT)) u_rem (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .dividend  (dividend),
      .step_en   (step_en),
      .fix_en    (fix_en),
      .trial_neg (trial_neg),
      .alu_sum   (alu_sum),
      .rem_q     (rem_q)
   );

   assign hi = rem_q[RW-1:WIDTH];
   assign lo = rem_q[WIDTH-1:0];

endmodule

// File: rtl/rdiv_chk.sv
module rdiv_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [WIDTH-1:0] dividend,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] hi,
   input logic [WIDTH-1:0] lo,
   input logic [WIDTH-1:0] dvs_q
);

   AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !done) |=> (busy && hi == '0 && lo == $past(dividend))); // R2

   AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
      (done && dvs_q != '0) |-> (hi < dvs_q)); // R3

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R4

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R4

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(hi) && $stable(lo))); // R4

   AST_DIVISOR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(dvs_q)); // R5

endmodule

bind rdiv_core rdiv_chk #(.WIDTH(WIDTH)) u_rdiv_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .dividend (dividend),
   .busy     (busy),
   .done     (done),
   .hi       (hi),
   .lo       (lo),
   .dvs_q    (dvs_q)
);

// File: tb/rdiv_core_tb.sv
module rdiv_core_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] dvd = '0, dvs = '0;
   logic        busy, done;
   logic [31:0] hi, lo;

   logic        start8 = 1'b0;
   logic [7:0]  dvd8 = '0, dvs8 = '0;
   logic        busy8, done8;
   logic [7:0]  hi8, lo8;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   rdiv_core #(.WIDTH(32), .RESTORE_EXPLICIT(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dvd), .divisor(dvs),
      .busy(busy), .done(done), .hi(hi), .lo(lo)
   );

   rdiv_core #(.WIDTH(8), .RESTORE_EXPLICIT(0)) u_dut8 (
      .clk(clk), .rst_n(rst_n), .start(start8), .dividend(dvd8), .divisor(dvs8),
      .busy(busy8), .done(done8), .hi(hi8), .lo(lo8)
   );

   // columns: dividend, divisor, quotient, remainder
   localparam int NV = 11;
   localparam logic [127:0] VEC [NV] = '{
      {32'd7,          32'd2,          32'd3,          32'd1},
      {32'd100,        32'd7,          32'd14,         32'd2},
      {32'd0,          32'd5,          32'd0,          32'd0},
      {32'd5,          32'd7,          32'd0,          32'd5},
      {32'hFFFF_FFFF,  32'd1,          32'hFFFF_FFFF,  32'd0},
      {32'hFFFF_FFFF,  32'h8000_0001,  32'd1,          32'h7FFF_FFFE},
      {32'h8000_0000,  32'hFFFF_FFFF,  32'd0,          32'h8000_0000},
      {32'h1234_5678,  32'd1000,       32'h0004_A90B,  32'h0000_0380},
      {32'hFFFF_FFFF,  32'hFFFF_FFFF,  32'd1,          32'd0},
      {32'h0001_0000,  32'd3,          32'h0000_5555,  32'd1},
      {32'hC000_0000,  32'h8000_0000,  32'd1,          32'h4000_0000}
   };

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic run32(input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] q, output logic [31:0] r, output int cyc);
      @(negedge clk);
      dvd = a; dvs = b; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(busy && hi == 32'd0 && lo == a, "R2 load", {31'd0, busy, lo}, {32'd1, a});
      cyc = 0;
      while (!done && cyc < 1000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
      chk(!busy, "R4 busy low with done", {63'd0, busy}, 64'd0);
      q = lo; r = hi;
   endtask

   task automatic run8(input logic [7:0] a, input logic [7:0] b,
                       output logic [7:0] q, output logic [7:0] r, output int cyc);
      @(negedge clk);
      dvd8 = a; dvs8 = b; start8 = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start8 = 1'b0;
      cyc = 0;
      while (!done8 && cyc < 100) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
      q = lo8; r = hi8;
   endtask

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL R4 watchdog: actual no completion expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] q, r, ea, eb, eq, er;
      logic [7:0]  q8, r8, eq8, er8;
      int          cyc, zeros;

      // R1 reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!busy && !done && hi == 0 && lo == 0, "R1 reset outputs",
          {busy, done, hi[29:0], lo}, 64'd0);
      chk(!busy8 && !done8 && hi8 == 0 && lo8 == 0, "R1 reset outputs narrow",
          {46'd0, busy8, done8, hi8, lo8}, 64'd0);
      rst_n = 1'b1;

      // R3 R7 R9 vector table
      for (int i = 0; i < NV; i++) begin
         ea = VEC[i][127:96]; eb = VEC[i][95:64];
         eq = VEC[i][63:32];  er = VEC[i][31:0];
         run32(ea, eb, q, r, cyc);
         chk(q == eq && r == er, (eb[31] ? "R9 top-bit divisor result" : "R3 result"),
             {q, r}, {eq, er});
         zeros = 32 - $countones(eq);
         chk(cyc == 32 + zeros, "R7 data-dependent latency", 64'(cyc), 64'(32 + zeros));
      end

      // R4 pulse width and hold
      @(negedge clk);
      chk(!done, "R4 done one cycle", {63'd0, done}, 64'd0);
      repeat (4) @(negedge clk);
      chk(hi == 32'h4000_0000 && lo == 32'd1, "R4 results held", {hi, lo}, {32'h4000_0000, 32'd1});

      // R6 divide by zero
      run32(32'h0BAD_F00D, 32'd0, q, r, cyc);
      chk(q == 32'hFFFF_FFFF && r == 32'h0BAD_F00D, "R6 zero divisor", {q, r},
          {32'hFFFF_FFFF, 32'h0BAD_F00D});
      chk(cyc == 32, "R7 latency all-ones quotient", 64'(cyc), 64'd32);

      // R5 start while busy is ignored
      @(negedge clk);
      dvd = 32'd1000; dvs = 32'd9; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      dvd = 32'd77; dvs = 32'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 1000) begin
         @(negedge clk);
         cyc++;
      end
      chk(lo == 32'd111 && hi == 32'd1, "R5 busy start ignored", {hi, lo}, {32'd1, 32'd111});

      // R8 R3 R6 narrow single-cycle variant grid
      for (int a = 0; a < 256; a += 37) begin
         for (int b = 0; b < 256; b += 29) begin
            run8(8'(a), 8'(b), q8, r8, cyc);
            if (b == 0) begin
               eq8 = 8'hFF; er8 = 8'(a);
            end else begin
               eq8 = 8'(a / b); er8 = 8'(a % b);
            end
            chk(q8 == eq8 && r8 == er8, (b == 0 ? "R6 narrow zero divisor" : "R3 narrow result"),
                {48'd0, q8, r8}, {48'd0, eq8, er8});
            chk(cyc == 8, "R8 fixed latency", 64'(cyc), 64'd8);
         end
      end
      run8(8'hFF, 8'h81, q8, r8, cyc);
      chk(q8 == 8'd1 && r8 == 8'h7E, "R9 narrow top-bit divisor", {48'd0, q8, r8}, {48'd0, 8'd1, 8'h7E});

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule